// File: doc/BRIEF.md
# Floating-Point Intermediate-Result Rounder

This block takes an intermediate result produced by an arithmetic datapath as if to infinite precision and turns it into a value that fits a double-format floating-point data register. The intermediate value carries a sign, a 12-bit two's-complement unbiased exponent and a 56-bit mantissa: an integer bit, a 52-bit fraction and three extra low-order bits (guard, round, sticky). The exponent is wide enough to hold values far outside the register's range, so overflow and underflow are decided on that exponent before it is converted to the 11-bit biased field.

Two controls choose the precision of the rounding (double keeps 53 significant bits, single keeps 24) and one of four rounding directions. Even when single precision is chosen, the rounded value is written in double format with the exponent checked against the single-precision range. The result and three flags (overflow, underflow, inexact) are registered and appear one clock after the inputs. The input mantissa is assumed to be normalised (integer bit set) or entirely zero; a clear integer bit is treated as a zero value.

Top module: `fpr_round_unit`

## Requirements
- R1: Outputs are registered: the result and flags for the inputs present at a rising clock edge appear after that edge; a synchronous active-low reset clears the result and all flags to zero.
- R2: In double precision the rounded significand is mantissa bits 55..3; bit 2 is the guard bit and bits 1..0 are ORed into the sticky bit; the output fraction (result bits 51..0) is the rounded significand below its integer bit.
- R3: Rounding mode code 00 rounds to nearest with ties to even, 01 toward zero, 10 toward plus infinity, 11 toward minus infinity; the increment is applied at the least significant kept bit.
- R4: When single precision is selected (prec_single = 1) the kept significand is mantissa bits 55..32, bit 31 is the guard bit, bits 30..0 form the sticky bit, and result bits 28..0 are zero.
- R5: When rounding carries out of the integer bit, the significand becomes a single leading one and the exponent is incremented by one before the range check.
- R6: Overflow is flagged when the rounded exponent exceeds 1023 (127 in single precision); the result is then infinity (exponent field all ones, fraction zero) in modes 00, in mode 10 for a positive sign and in mode 11 for a negative sign, and otherwise the largest finite value of the selected precision with the input sign.
- R7: Underflow is flagged when the rounded exponent is below -1022 (-126 in single precision); the result is then zero carrying the input sign.
- R8: The inexact flag is set when any discarded bit (guard or sticky) is one, and is always set on overflow or underflow.
- R9: For an in-range result, result bit 63 is the input sign and bits 62..52 are the rounded exponent plus 1023 in 11 bits.
- R10: An all-zero mantissa yields a signed zero with no flag set, whatever the exponent and mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_sign | input | 1 | Sign of the intermediate result |
| in_exp | input | 12 | Unbiased two's-complement exponent |
| in_mant | input | 56 | Integer bit, 52-bit fraction, guard, round, sticky |
| prec_single | input | 1 | 1 selects single-precision rounding |
| rnd_mode | input | 2 | Rounding direction code |
| out_result | output | 64 | Rounded value in double format |
| out_ovf | output | 1 | Overflow flag |
| out_unf | output | 1 | Underflow flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
The hardest situation to reach is a carry out of the integer bit that pushes an exponent sitting exactly at the range limit over it, because it needs an all-ones kept significand, discarded bits that trigger an increment in the chosen mode, and an exponent at 1023 or 127 at the same time. The stimulus is a product sweep: every mode, both precisions and both signs crossed with exponents on each side of both limits and with mantissas built to sit on ties, on pure sticky, on full carry in each precision, plus pseudo-random patterns, each compared with an arithmetic model in the bench.

// File: rtl/fpr_pkg.sv
// Package: shared types for the intermediate-result rounder.
// Assumes: rounding codes are fixed by the control field encoding.
package fpr_pkg;
    typedef enum logic [1:0] {
        RM_NEAR_EVEN = 2'b00,
        RM_TO_ZERO   = 2'b01,
        RM_TO_POS    = 2'b10,
        RM_TO_NEG    = 2'b11
    } rnd_mode_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inx;
    } fpr_flags_t;
endpackage

// File: rtl/fpr_split.sv
// Module: fpr_split
// Splits the intermediate mantissa at the rounding point for the selected
// precision: the kept significand (lower positions cleared in single mode),
// its least significant kept bit, the guard bit and the collapsed sticky bit.
// Assumes: GRS_W >= 2 and SGL_KEEP < SIG_W.
module fpr_split #(
    parameter int FRAC_W   = 52,
    parameter int GRS_W    = 3,
    parameter int SGL_KEEP = 24,
    localparam int SIG_W    = FRAC_W + 1,
    localparam int MANT_W   = SIG_W + GRS_W,
    localparam int SGL_DROP = SIG_W - SGL_KEEP
) (
    input  logic [MANT_W-1:0] mant,
    input  logic              prec_single,
    output logic [SIG_W-1:0]  sig_trunc,
    output logic              lsb,
    output logic              guard,
    output logic              sticky
);
    logic [SIG_W-1:0] sig_dbl, sig_sgl;
    logic             lsb_dbl, lsb_sgl;
    logic             grd_dbl, grd_sgl;
    logic             stk_dbl, stk_sgl;

    // Double split: kept bits sit directly above the extra low-order bits.
    assign sig_dbl = mant[MANT_W-1:GRS_W];
    assign lsb_dbl = mant[GRS_W];
    assign grd_dbl = mant[GRS_W-1];

    generate
        if (GRS_W == 2) begin : g_stk_one
            assign stk_dbl = mant[0];
        end else begin : g_stk_many
            assign stk_dbl = |mant[GRS_W-2:0];
        end
    endgenerate

    // Single split: everything below the 24th significant bit is discarded.
    assign sig_sgl = {mant[MANT_W-1 -: SGL_KEEP], {SGL_DROP{1'b0}}};
    assign lsb_sgl = mant[GRS_W+SGL_DROP];
    assign grd_sgl = mant[GRS_W+SGL_DROP-1];
    assign stk_sgl = |mant[GRS_W+SGL_DROP-2:0];

    // Select the split for the requested precision.
    always_comb begin
        if (prec_single) begin
            sig_trunc = sig_sgl;
            lsb       = lsb_sgl;
            guard     = grd_sgl;
            sticky    = stk_sgl;
        end else begin
            sig_trunc = sig_dbl;
            lsb       = lsb_dbl;
            guard     = grd_dbl;
            sticky    = stk_dbl;
        end
    end
endmodule

// File: rtl/fpr_round_add.sv
// Module: fpr_round_add
// Decides the rounding increment from mode, sign and the split bits, adds it
// at the kept lsb and renormalises a carry out of the integer bit by
// bumping the exponent.
// Assumes: sig_trunc has zeros below the kept lsb in single mode.
module fpr_round_add
    import fpr_pkg::*;
#(
    parameter int SIG_W    = 53,
    parameter int SGL_DROP = 29,
    parameter int EXP_W    = 12
) (
    input  logic                    sign,
    input  rnd_mode_e               mode,
    input  logic                    prec_single,
    input  logic [SIG_W-1:0]        sig_trunc,
    input  logic                    lsb,
    input  logic                    guard,
    input  logic                    sticky,
    input  logic signed [EXP_W-1:0] exp_in,
    output logic [SIG_W-1:0]        sig_rnd,
    output logic signed [EXP_W:0]   exp_rnd,
    output logic                    inexact_rnd
);
    logic             inc;
    logic [SIG_W:0]   step;
    logic [SIG_W:0]   sum;
    logic             carry;

    // Increment decision for each rounding direction.
    always_comb begin
        case (mode)
            RM_NEAR_EVEN: inc = guard & (sticky | lsb);
            RM_TO_ZERO:   inc = 1'b0;
            RM_TO_POS:    inc = ~sign & (guard | sticky);
            RM_TO_NEG:    inc = sign & (guard | sticky);
            default:      inc = 1'b0;
        endcase
    end

    assign inexact_rnd = guard | sticky;

    // Weight of one unit in the last kept place.
    assign step = prec_single ? ((SIG_W+1)'(1) << SGL_DROP) : (SIG_W+1)'(1);

    // Add the increment and renormalise on carry out.
    always_comb begin
        sum     = {1'b0, sig_trunc} + (inc ? step : '0);
        carry   = sum[SIG_W];
        sig_rnd = carry ? {1'b1, {(SIG_W-1){1'b0}}} : sum[SIG_W-1:0];
        exp_rnd = {exp_in[EXP_W-1], exp_in} + (EXP_W+1)'(carry);
    end
endmodule

// File: rtl/fpr_range_pack.sv
// Module: fpr_range_pack
// Checks the rounded exponent against the range of the selected precision,
// picks infinity, largest finite value or signed zero on violation, and
// otherwise packs sign, biased exponent and fraction into double format.
// Assumes: a clear leading significand bit means a zero input.
module fpr_range_pack
    import fpr_pkg::*;
#(
    parameter int SIG_W     = 53,
    parameter int EXP_W     = 12,
    parameter int OUT_EXP_W = 11,
    parameter int SGL_KEEP  = 24,
    parameter int DBL_BIAS  = 1023,
    parameter int SGL_BIAS  = 127,
    localparam int FRAC_W   = SIG_W - 1,
    localparam int SGL_DROP = SIG_W - SGL_KEEP,
    localparam int RES_W    = 1 + OUT_EXP_W + FRAC_W
) (
    input  logic                  sign,
    input  rnd_mode_e             mode,
    input  logic                  prec_single,
    input  logic [SIG_W-1:0]      sig_rnd,
    input  logic signed [EXP_W:0] exp_rnd,
    input  logic                  inexact_rnd,
    output logic [RES_W-1:0]      result,
    output fpr_flags_t            flags
);
    logic signed [EXP_W:0] emax, emin;
    logic                  is_zero, too_big, too_small, to_inf;
    logic [OUT_EXP_W-1:0]  max_exp, norm_exp;
    logic [FRAC_W-1:0]     max_frac;

    // Range limits for the selected precision.
    always_comb begin
        emax = prec_single ? (EXP_W+1)'(SGL_BIAS) : (EXP_W+1)'(DBL_BIAS);
        emin = (EXP_W+1)'(1) - emax;
    end

    assign is_zero   = ~sig_rnd[SIG_W-1];
    assign too_big   = exp_rnd > emax;
    assign too_small = exp_rnd < emin;

    // Overflow target: infinity unless the direction points back toward zero.
    always_comb begin
        case (mode)
            RM_NEAR_EVEN: to_inf = 1'b1;
            RM_TO_ZERO:   to_inf = 1'b0;
            RM_TO_POS:    to_inf = ~sign;
            RM_TO_NEG:    to_inf = sign;
            default:      to_inf = 1'b1;
        endcase
    end

    // Field values for the largest finite number and for a normal result.
    always_comb begin
        max_exp  = OUT_EXP_W'(emax + (EXP_W+1)'(DBL_BIAS));
        max_frac = prec_single ? {{(SGL_KEEP-1){1'b1}}, {SGL_DROP{1'b0}}} : '1;
        norm_exp = OUT_EXP_W'(exp_rnd + (EXP_W+1)'(DBL_BIAS));
    end

    // Final result and flag selection.
    always_comb begin
        flags = '0;
        if (is_zero) begin
            result = {sign, {(RES_W-1){1'b0}}};
        end else if (too_big) begin
            flags.ovf = 1'b1;
            flags.inx = 1'b1;
            result    = to_inf ? {sign, {OUT_EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                               : {sign, max_exp, max_frac};
        end else if (too_small) begin
            flags.unf = 1'b1;
            flags.inx = 1'b1;
            result    = {sign, {(RES_W-1){1'b0}}};
        end else begin
            flags.inx = inexact_rnd;
            result    = {sign, norm_exp, sig_rnd[FRAC_W-1:0]};
        end
    end
endmodule

// File: rtl/fpr_round_unit.sv
// Module: fpr_round_unit (top)
// Rounds an infinite-precision intermediate result to double or single
// precision, checks range on the wide exponent and registers the double
// format result with overflow, underflow and inexact flags.
// Assumes: input mantissa normalised (integer bit set) or all zero.
module fpr_round_unit
    import fpr_pkg::*;
#(
    parameter int FRAC_W    = 52,
    parameter int GRS_W     = 3,
    parameter int EXP_W     = 12,
    parameter int OUT_EXP_W = 11,
    parameter int SGL_KEEP  = 24,
    parameter int DBL_BIAS  = 1023,
    parameter int SGL_BIAS  = 127,
    localparam int SIG_W    = FRAC_W + 1,
    localparam int MANT_W   = SIG_W + GRS_W,
    localparam int SGL_DROP = SIG_W - SGL_KEEP,
    localparam int RES_W    = 1 + OUT_EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_sign,
    input  logic [EXP_W-1:0]  in_exp,
    input  logic [MANT_W-1:0] in_mant,
    input  logic              prec_single,
    input  logic [1:0]        rnd_mode,
    output logic [RES_W-1:0]  out_result,
    output logic              out_ovf,
    output logic              out_unf,
    output logic              out_inexact
);
    rnd_mode_e             mode;
    logic [SIG_W-1:0]      sig_trunc, sig_rnd;
    logic                  lsb, guard, sticky, inexact_rnd;
    logic signed [EXP_W:0] exp_rnd;
    logic [RES_W-1:0]      result_d;
    fpr_flags_t            flags_d;

    assign mode = rnd_mode_e'(rnd_mode);

    fpr_split #(
        .FRAC_W   (FRAC_W),
        .GRS_W    (GRS_W),
        .SGL_KEEP (SGL_KEEP)
    ) split_i (
        .mant        (in_mant),
        .prec_single (prec_single),
        .sig_trunc   (sig_trunc),
        .lsb         (lsb),
        .guard       (guard),
        .sticky      (sticky)
    );

    fpr_round_add #(
        .SIG_W    (SIG_W),
        .SGL_DROP (SGL_DROP),
        .EXP_W    (EXP_W)
    ) round_i (
        .sign        (in_sign),
        .mode        (mode),
        .prec_single (prec_single),
        .sig_trunc   (sig_trunc),
        .lsb         (lsb),
        .guard       (guard),
        .sticky      (sticky),
        .exp_in      ($signed(in_exp)),
        .sig_rnd     (sig_rnd),
        .exp_rnd     (exp_rnd),
        .inexact_rnd (inexact_rnd)
    );

    fpr_range_pack #(
        .SIG_W     (SIG_W),
        .EXP_W     (EXP_W),
        .OUT_EXP_W (OUT_EXP_W),
        .SGL_KEEP  (SGL_KEEP),
        .DBL_BIAS  (DBL_BIAS),
        .SGL_BIAS  (SGL_BIAS)
    ) pack_i (
        .sign        (in_sign),
        .mode        (mode),
        .prec_single (prec_single),
        .sig_rnd     (sig_rnd),
        .exp_rnd     (exp_rnd),
        .inexact_rnd (inexact_rnd),
        .result      (result_d),
        .flags       (flags_d)
    );

    // Output register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_result  <= '0;
            out_ovf     <= 1'b0;
            out_unf     <= 1'b0;
            out_inexact <= 1'b0;
        end else begin
            out_result  <= result_d;
            out_ovf     <= flags_d.ovf;
            out_unf     <= flags_d.unf;
            out_inexact <= flags_d.inx;
        end
    end

    // R1: the first cycle after reset shows cleared outputs.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (out_result == '0 && !out_ovf && !out_unf && !out_inexact));

    // R6, R7: a result cannot both overflow and underflow.
    p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_ovf && out_unf));

    // R8: overflow always reports inexact.
    p_ovf_inexact_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_ovf |-> out_inexact);

    // R7: underflow leaves only the sign bit.
    p_unf_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_unf |-> (out_result[RES_W-2:0] == '0 && out_inexact));

    // R4: single precision clears the fraction below the kept bits.
    p_single_low_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(prec_single) |-> (out_result[SGL_DROP-1:0] == '0));

    // R3, R6: rounding toward zero never yields infinity.
    p_rz_finite_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rnd_mode) == 2'b01) |-> (out_result[RES_W-2 -: OUT_EXP_W] != '1));

    // R10: a zero mantissa gives a quiet signed zero.
    p_zero_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_mant) == '0) |->
            (!out_ovf && !out_unf && !out_inexact && out_result[RES_W-2:0] == '0));
endmodule

// File: tb/fpr_round_unit_tb_top.sv
`timescale 1ns/1ps
module fpr_round_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_sign = 1'b0;
    logic [11:0] in_exp = '0;
    logic [55:0] in_mant = '0;
    logic        prec_single = 1'b0;
    logic [1:0]  rnd_mode = '0;
    logic [63:0] out_result;
    logic        out_ovf, out_unf, out_inexact;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    fpr_round_unit dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_sign     (in_sign),
        .in_exp      (in_exp),
        .in_mant     (in_mant),
        .prec_single (prec_single),
        .rnd_mode    (rnd_mode),
        .out_result  (out_result),
        .out_ovf     (out_ovf),
        .out_unf     (out_unf),
        .out_inexact (out_inexact)
    );

    // Arithmetic model of the requirements.
    task automatic model(input logic s, input int e, input logic [55:0] m,
                         input logic sgl, input logic [1:0] md,
                         output logic [63:0] res, output logic ovf,
                         output logic unf, output logic inx, output logic cy);
        int          k, sh, ee, emax, emin;
        logic [63:0] kept, rem, half, sum, mx;
        logic        g, st, inc, inf;
        k    = sgl ? 29 : 0;
        sh   = 3 + k;
        kept = 64'(m) >> sh;
        rem  = 64'(m) & ((64'd1 << sh) - 1);
        half = 64'd1 << (sh - 1);
        g    = rem >= half;
        st   = (rem & (half - 1)) != 0;
        case (md)
            2'b00:   inc = g && (st || kept[0]);
            2'b01:   inc = 1'b0;
            2'b10:   inc = !s && (g || st);
            default: inc = s && (g || st);
        endcase
        sum = kept + 64'(inc);
        ee  = e;
        cy  = 1'b0;
        if ((sum >> (53 - k)) != 0) begin
            sum = sum >> 1;
            ee  = ee + 1;
            cy  = 1'b1;
        end
        emax = sgl ? 127 : 1023;
        emin = 1 - emax;
        ovf = 1'b0; unf = 1'b0; inx = g || st;
        if (m == 0) begin
            res = {s, 63'd0};
            inx = 1'b0;
        end else if (ee > emax) begin
            ovf = 1'b1; inx = 1'b1;
            inf = (md == 2'b00) || (md == 2'b10 && !s) || (md == 2'b11 && s);
            mx  = sgl ? (((64'd1 << 23) - 1) << 29) : ((64'd1 << 52) - 1);
            res = inf ? {s, 11'h7FF, 52'd0} : {s, 11'(emax + 1023), mx[51:0]};
        end else if (ee < emin) begin
            unf = 1'b1; inx = 1'b1;
            res = {s, 63'd0};
        end else begin
            mx  = sum << k;
            res = {s, 11'(ee + 1023), mx[51:0]};
        end
    endtask

    task automatic check(input string tag, input logic [66:0] act, input logic [66:0] exp_v);
        checks++;
        if (act !== exp_v) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp_v);
        end
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL R1: watchdog expired, actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int          exps [15] = '{-2048, -1023, -1022, -1021, -127, -126, -125, 0,
                                   126, 127, 128, 1022, 1023, 1024, 2047};
        logic [55:0] pats [18];
        logic [63:0] lfsr, rexp;
        logic        eo, eu, ei, cy;
        string       tag;
        pats[0] = 56'h80_0000_0000_0000;
        pats[1] = 56'hFF_FFFF_FFFF_FFFF;
        pats[2] = 56'h80_0000_0000_0004;
        pats[3] = 56'h80_0000_0000_000C;
        pats[4] = 56'h80_0000_8000_0000;
        pats[5] = 56'h80_0001_8000_0000;
        pats[6] = 56'h80_0000_0000_0001;
        pats[7] = 56'hFF_FFFF_FF00_0000;
        pats[8] = 56'h00_0000_0000_0000;
        pats[9] = 56'hFF_FFFF_FFFF_FFF8;
        lfsr = 64'h9E37_79B9_7F4A_7C15;
        for (int i = 10; i < 18; i++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 7);
            lfsr = lfsr ^ (lfsr << 17);
            pats[i] = lfsr[55:0] | 56'h80_0000_0000_0000;
        end

        // R1: reset state.
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset", {out_result, out_ovf, out_unf, out_inexact}, 67'd0);
        rst_n = 1'b1;

        for (int md = 0; md < 4; md++)
            for (int sg = 0; sg < 2; sg++)
                for (int sn = 0; sn < 2; sn++)
                    for (int ei_i = 0; ei_i < 15; ei_i++)
                        for (int pi = 0; pi < 18; pi++) begin
                            in_sign     = sn[0];
                            in_exp      = 12'(exps[ei_i]);
                            in_mant     = pats[pi];
                            prec_single = sg[0];
                            rnd_mode    = 2'(md);
                            model(sn[0], exps[ei_i], pats[pi], sg[0], 2'(md),
                                  rexp, eo, eu, ei, cy);
                            @(posedge clk);
                            @(negedge clk);
                            if (pats[pi] == 0)  tag = "R10 zero";
                            else if (eo)        tag = "R6 overflow";
                            else if (eu)        tag = "R7 underflow";
                            else if (cy)        tag = "R5 carry";
                            else if (sg != 0)   tag = "R4 single R3 R8 R9";
                            else                tag = "R2 double R3 R8 R9";
                            check(tag, {out_result, out_ovf, out_unf, out_inexact},
                                  {rexp, eo, eu, ei});
                        end

        // R1: reset applied mid-stream clears outputs again.
        in_mant = 56'hFF_FFFF_FFFF_FFFF;
        in_exp  = 12'd2047;
        rst_n   = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset again", {out_result, out_ovf, out_unf, out_inexact}, 67'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule